// File: doc/BRIEF.md
# Dual-Rounding Integer Divider

This block divides a W-bit dividend by a W-bit divisor and returns a W-bit quotient. Each operand carries its own signedness flag. A mode input picks one of two rounding rules. Truncating mode rounds toward zero. Flooring mode rounds toward negative infinity. A one-cycle `start` pulse, taken while the block is idle, launches an operation. `done` rises on the edge that stores the result.

There are three ways to finish. A zero divisor finishes at once and raises a divide-by-zero flag. A positive power-of-two divisor takes a shift path and also finishes at once. On that path the floored quotient comes from a right shift, arithmetic for a signed dividend. A truncating result adds one when the dividend is negative and the shifted-out bits are not all zero. Every other divisor goes to a restoring engine that works on magnitudes and produces one quotient bit per cycle. Its magnitude quotient is then negated for a negative result. In flooring mode it is also stepped down by one when the remainder is nonzero.

Top module: `dual_round_divider`

## Requirements
- R1: With `floor_mode`=0, `q_out` is the exact quotient of the two operand values rounded toward zero, taken modulo 2^W.
- R2: With `floor_mode`=1, `q_out` is the exact quotient rounded toward negative infinity, taken modulo 2^W. It differs from the R1 result only when the signs of the operand values differ and the division is inexact; then it is one less.
- R3: An operand whose flag (`a_signed`, `b_signed`) is 0 is read as an unsigned value in 0..2^W-1. An operand whose flag is 1 is read as two's complement.
- R4: A zero divisor, accepted at an edge, sets `done`=1, `div_zero`=1 and `q_out`=all ones on that same edge.
- R5: A divisor whose value is a positive power of two (exactly one bit set, and bit W-1 clear when `b_signed`=1) gives `done`=1 on the accepting edge, and `busy` stays 0.
- R6: Any other nonzero divisor sets `busy`=1 on the accepting edge. `busy` drops and `done` rises on the edge W+1 cycles later, and `done` stays 0 while `busy` is 1.
- R7: The most negative signed dividend divided by signed -1 gives the most negative value (0x8000 for W=16), with `div_zero`=0, in both modes.
- R8: `start` is ignored while `busy`=1. The result delivered is that of the accepted operation, with exactly one `done`.
- R9: `q_out` and `div_zero` change only on an edge that raises `done`. Operand and mode inputs changed without `start` do not affect them.
- R10: After reset, `busy`, `done`, `div_zero` and `q_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a division (taken when idle) |
| a_in | input | W | Dividend |
| b_in | input | W | Divisor |
| a_signed | input | 1 | Dividend is two's complement |
| b_signed | input | 1 | Divisor is two's complement |
| floor_mode | input | 1 | 1: round toward negative infinity, 0: toward zero |
| busy | output | 1 | Iterative engine in use |
| done | output | 1 | Result stored on this edge |
| div_zero | output | 1 | Last result came from a zero divisor |
| q_out | output | W | Quotient |

## Verification
The bench sends inexact negative quotients through both the shift path and the iterative path in both modes. A design that mixed up the correction would be off by one there, while exact and positive cases would still look right. Mixed signedness cases matter most around the shift path: a huge unsigned dividend, and an unsigned divisor with only its top bit set. Here a design that applied sign logic to an unsigned operand would return a wrong sign or a wrong magnitude. The corner cases also include the most negative dividend over -1, which must wrap and not flag anything, and a zero divisor, which must answer at once with all ones. A `start` sent while busy must not corrupt the running division or add a second `done`.

// File: rtl/divr_pkg.sv
package divr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } divr_state_t;
endpackage

// File: rtl/divr_pow2_path.sv
// Single-cycle quotient for a positive power-of-two divisor.
module divr_pow2_path #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         a_signed,
  input  logic         b_signed,
  input  logic         floor_mode,
  output logic         hit,
  output logic [W-1:0] q
);
  localparam int SW = $clog2(W);
  localparam logic [W-1:0] ONE = W'(1);

  logic [SW-1:0]        sh;
  logic signed [W-1:0]  a_s;
  logic signed [W-1:0]  ashr;
  logic [W-1:0]         lshr;
  logic [W-1:0]         floor_q;
  logic [W-1:0]         low_mask;
  logic                 low_nz;
  logic                 a_neg;
  logic                 bump;
  logic                 single_bit;

  always_comb begin
    sh = '0;
    for (int i = 0; i < W; i++) begin
      if (b[i]) sh = SW'(i);
    end
  end

  assign low_mask   = b - ONE;
  assign single_bit = (b != '0) && ((b & low_mask) == '0);
  assign hit        = single_bit && !(b_signed && b[W-1]);

  assign a_s     = a;
  assign ashr    = a_s >>> sh;
  assign lshr    = a >> sh;
  assign floor_q = a_signed ? $unsigned(ashr) : lshr;

  // shifted-out bits nonzero means the division was inexact
  assign low_nz = |(a & low_mask);
  assign a_neg  = a_signed && a[W-1];
  assign bump   = !floor_mode && a_neg && low_nz;
  assign q      = bump ? (floor_q + ONE) : floor_q;
endmodule

// File: rtl/divr_iter_core.sv
// Restoring divider on unsigned magnitudes, one quotient bit per cycle.
module divr_iter_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] dvd_mag,
  input  logic [W-1:0] dvs_mag,
  output logic [W-1:0] quo_mag,
  output logic         rem_nz,
  output logic         finished
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  acc;
  logic [W-1:0]  rem;
  logic [W-1:0]  dvs_r;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    shifted;
  logic [W:0]    diff;
  logic          ge;

  assign shifted = {rem, acc[W-1]};
  assign diff    = shifted - {1'b0, dvs_r};
  assign ge      = shifted >= {1'b0, dvs_r};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      rem      <= '0;
      dvs_r    <= '0;
      cnt      <= '0;
      run      <= 1'b0;
      finished <= 1'b0;
    end else begin
      finished <= 1'b0;
      if (load) begin
        acc   <= dvd_mag;
        rem   <= '0;
        dvs_r <= dvs_mag;
        cnt   <= '0;
        run   <= 1'b1;
      end else if (run) begin
        acc <= {acc[W-2:0], ge};
        rem <= ge ? diff[W-1:0] : shifted[W-1:0];
        cnt <= cnt + CW'(1);
        if (cnt == LAST) begin
          run      <= 1'b0;
          finished <= 1'b1;
        end
      end
    end
  end

  assign quo_mag = acc;
  assign rem_nz  = |rem;
endmodule

// File: rtl/divr_sign_fix.sv
// Turns a magnitude quotient into the signed result under the chosen rounding.
module divr_sign_fix #(
  parameter int W = 16
) (
  input  logic [W-1:0] qmag,
  input  logic         neg,
  input  logic         rem_nz,
  input  logic         floor_mode,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    if (!neg)                     q = qmag;
    else if (floor_mode && rem_nz) q = ~qmag;          // -(qmag) - 1
    else                          q = ~qmag + ONE;     // -(qmag)
  end
endmodule

// File: rtl/dual_round_divider.sv
module dual_round_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         a_signed,
  input  logic         b_signed,
  input  logic         floor_mode,
  output logic         busy,
  output logic         done,
  output logic         div_zero,
  output logic [W-1:0] q_out
);
  import divr_pkg::*;

  localparam logic [W-1:0] ONE = W'(1);

  divr_state_t  st;
  logic         accept;
  logic         b_zero;
  logic         a_neg;
  logic         b_neg;
  logic [W-1:0] a_mag;
  logic [W-1:0] b_mag;
  logic         fast_hit;
  logic [W-1:0] fast_q;
  logic         core_load;
  logic [W-1:0] core_qmag;
  logic         core_rem_nz;
  logic         core_fin;
  logic         neg_r;
  logic         floor_r;
  logic [W-1:0] slow_q;

  assign accept = start && (st == ST_IDLE);
  assign b_zero = (b_in == '0);
  assign a_neg  = a_signed && a_in[W-1];
  assign b_neg  = b_signed && b_in[W-1];
  assign a_mag  = a_neg ? (~a_in + ONE) : a_in;
  assign b_mag  = b_neg ? (~b_in + ONE) : b_in;

  divr_pow2_path #(.W(W)) u_pow2 (
    .a          (a_in),
    .b          (b_in),
    .a_signed   (a_signed),
    .b_signed   (b_signed),
    .floor_mode (floor_mode),
    .hit        (fast_hit),
    .q          (fast_q)
  );

  assign core_load = accept && !b_zero && !fast_hit;

  divr_iter_core #(.W(W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .load     (core_load),
    .dvd_mag  (a_mag),
    .dvs_mag  (b_mag),
    .quo_mag  (core_qmag),
    .rem_nz   (core_rem_nz),
    .finished (core_fin)
  );

  divr_sign_fix #(.W(W)) u_fix (
    .qmag       (core_qmag),
    .neg        (neg_r),
    .rem_nz     (core_rem_nz),
    .floor_mode (floor_r),
    .q          (slow_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      done     <= 1'b0;
      div_zero <= 1'b0;
      q_out    <= '0;
      neg_r    <= 1'b0;
      floor_r  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            if (b_zero) begin
              q_out    <= '1;
              div_zero <= 1'b1;
              done     <= 1'b1;
            end else if (fast_hit) begin
              q_out    <= fast_q;
              div_zero <= 1'b0;
              done     <= 1'b1;
            end else begin
              neg_r   <= a_neg ^ b_neg;
              floor_r <= floor_mode;
              st      <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (core_fin) begin
            q_out    <= slow_q;
            div_zero <= 1'b0;
            done     <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st == ST_RUN);
endmodule

// File: rtl/dual_round_divider_chk.sv
module dual_round_divider_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] b_in,
  input logic         b_signed,
  input logic         busy,
  input logic         done,
  input logic         div_zero,
  input logic [W-1:0] q_out
);
  AST_DZ_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    div_zero |-> (q_out == {W{1'b1}})); // R4
  AST_DZ_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && b_in == '0) |=> (done && div_zero && !busy)); // R4
  AST_POW2_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && $countones(b_in) == 1 && !(b_signed && b_in[W-1]))
      |=> (done && !busy && !div_zero)); // R5
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R6
  AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(q_out) && $stable(div_zero))); // R9
endmodule

bind dual_round_divider dual_round_divider_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .b_in     (b_in),
  .b_signed (b_signed),
  .busy     (busy),
  .done     (done),
  .div_zero (div_zero),
  .q_out    (q_out)
);

// File: tb/dual_round_divider_bench.sv
module dual_round_divider_bench;
  localparam int W = 16;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;
  localparam int NVEC = 20;

  // {a, b, a_signed, b_signed, floor_mode, expected quotient}
  localparam logic [50:0] VEC [NVEC] = '{
    {16'h0007, 16'h0002, 1'b1, 1'b1, 1'b0, 16'h0003},
    {16'hFFF9, 16'h0002, 1'b1, 1'b1, 1'b0, 16'hFFFD},
    {16'hFFF9, 16'h0002, 1'b1, 1'b1, 1'b1, 16'hFFFC},
    {16'hFFF8, 16'h0004, 1'b1, 1'b1, 1'b1, 16'hFFFE},
    {16'hFFF9, 16'h0003, 1'b1, 1'b1, 1'b0, 16'hFFFE},
    {16'hFFF9, 16'h0003, 1'b1, 1'b1, 1'b1, 16'hFFFD},
    {16'h0007, 16'hFFFD, 1'b1, 1'b1, 1'b1, 16'hFFFD},
    {16'hFFF9, 16'hFFFD, 1'b1, 1'b1, 1'b1, 16'h0002},
    {16'h0064, 16'h0007, 1'b1, 1'b1, 1'b0, 16'h000E},
    {16'hFFF9, 16'h0002, 1'b0, 1'b0, 1'b1, 16'h7FFC},
    {16'hFFF9, 16'hFFFD, 1'b0, 1'b1, 1'b1, 16'hAAAD},
    {16'hFFF9, 16'h8000, 1'b1, 1'b0, 1'b1, 16'hFFFF},
    {16'hFFF9, 16'h8000, 1'b1, 1'b0, 1'b0, 16'h0000},
    {16'h8000, 16'h0001, 1'b1, 1'b1, 1'b0, 16'h8000},
    {16'h3039, 16'h0001, 1'b0, 1'b0, 1'b0, 16'h3039},
    {16'hFFFF, 16'h7FFF, 1'b1, 1'b1, 1'b1, 16'hFFFF},
    {16'h03E8, 16'hFFF6, 1'b1, 1'b1, 1'b0, 16'hFF9C},
    {16'hFC17, 16'h000A, 1'b1, 1'b1, 1'b1, 16'hFF9B},
    {16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 16'h0001},
    {16'h0005, 16'h0007, 1'b1, 1'b1, 1'b1, 16'h0000}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         a_signed = 1'b0;
  logic         b_signed = 1'b0;
  logic         floor_mode = 1'b0;
  logic         busy;
  logic         done;
  logic         div_zero;
  logic [W-1:0] q_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  dual_round_divider #(.W(W)) u_dual_round_divider (
    .clk (clk), .rst (rst), .start (start),
    .a_in (a_in), .b_in (b_in), .a_signed (a_signed), .b_signed (b_signed),
    .floor_mode (floor_mode), .busy (busy), .done (done),
    .div_zero (div_zero), .q_out (q_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Launch one operation; lat = edges after the accepting edge until done.
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic as, input logic bs, input logic fl,
                        output int lat, output logic busy0);
    @(negedge clk);
    a_in = a; b_in = b; a_signed = as; b_signed = bs; floor_mode = fl;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy0 = busy;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    logic busy0;
    logic [W-1:0] held_q;
    int ndone;

    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy == 1'b0 && done == 1'b0, "R10 busy/done", {busy, done}, 0);
    check(q_out == '0 && div_zero == 1'b0, "R10 q/div_zero", {div_zero, q_out}, 0);
    rst = 1'b0;

    // R1 R2 R3 R5 R6: table of vectors
    for (int k = 0; k < NVEC; k++) begin
      logic [W-1:0] va, vb, vexp;
      logic vas, vbs, vfl, pow2;
      int exp_lat;
      va = VEC[k][50:35]; vb = VEC[k][34:19];
      vas = VEC[k][18]; vbs = VEC[k][17]; vfl = VEC[k][16]; vexp = VEC[k][15:0];
      pow2 = ($countones(vb) == 1) && !(vbs && vb[W-1]);
      exp_lat = pow2 ? 0 : W + 1;
      run_op(va, vb, vas, vbs, vfl, lat, busy0);
      check(q_out == vexp, vfl ? "R2 R3 floored quotient" : "R1 R3 truncated quotient",
            q_out, vexp);
      check(div_zero == 1'b0, "R1 R2 no div_zero", div_zero, 0);
      check(lat == exp_lat, pow2 ? "R5 latency" : "R6 latency", lat, exp_lat);
      check(busy0 == !pow2, pow2 ? "R5 busy stays low" : "R6 busy raised", busy0, !pow2);
    end

    // R4: zero divisor, signed and unsigned
    run_op(16'h1234, 16'h0000, 1'b1, 1'b1, 1'b0, lat, busy0);
    check(div_zero == 1'b1 && q_out == 16'hFFFF, "R4 signed zero divisor", {div_zero, q_out}, 17'h1FFFF);
    check(lat == 0 && busy0 == 1'b0, "R4 zero divisor latency", lat, 0);
    run_op(16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, lat, busy0);
    check(div_zero == 1'b1 && q_out == 16'hFFFF, "R4 unsigned zero divisor", {div_zero, q_out}, 17'h1FFFF);

    // R7: most negative / -1 in both modes
    run_op(16'h8000, 16'hFFFF, 1'b1, 1'b1, 1'b0, lat, busy0);
    check(q_out == 16'h8000 && div_zero == 1'b0, "R7 wrap truncating", {div_zero, q_out}, 16'h8000);
    run_op(16'h8000, 16'hFFFF, 1'b1, 1'b1, 1'b1, lat, busy0);
    check(q_out == 16'h8000 && div_zero == 1'b0, "R7 wrap flooring", {div_zero, q_out}, 16'h8000);

    // R8: start held high with other operands while busy
    @(negedge clk);
    a_in = 16'h0064; b_in = 16'h0007; a_signed = 1'b1; b_signed = 1'b1; floor_mode = 1'b0;
    start = 1'b1;
    @(negedge clk);
    a_in = 16'h0000; b_in = 16'h0000; floor_mode = 1'b1;
    ndone = 0;
    for (int c = 0; c < 8; c++) begin
      if (done) ndone++;
      @(negedge clk);
    end
    start = 1'b0;
    for (int c = 0; c < W + 4; c++) begin
      if (done) begin
        ndone++;
        check(q_out == 16'h000E && div_zero == 1'b0, "R8 result of accepted op", q_out, 16'h000E);
      end
      @(negedge clk);
    end
    check(ndone == 1, "R8 single done", ndone, 1);

    // R9: inputs change without start, outputs hold
    held_q = q_out;
    a_in = 16'hFFF9; b_in = 16'h0002; a_signed = 1'b0; b_signed = 1'b0; floor_mode = 1'b0;
    repeat (4) @(negedge clk);
    b_in = 16'h0000;
    repeat (4) @(negedge clk);
    check(q_out == held_q && div_zero == 1'b0 && done == 1'b0, "R9 outputs held", q_out, held_q);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule